// File: doc/BRIEF.md
# Paired-Beat Floating-Point Request Receiver

This block sits at the edge of a floating-point unit. It takes request words from an on-chip interconnect. Every request reaches it as two 124-bit beats. A beat is taken only in a cycle where the ready strobe is high. The first beat carries the request tag, the opcode, the rounding mode, the condition-code selector and the first operand. The second beat carries the second operand. Any number of idle cycles may separate the two beats.

The block joins the two beats into one request. It gives one request-valid pulse for each completed pair. It also watches the traffic for protocol breaches and keeps a sticky flag for each kind of breach. There are four kinds: a broken beat order, a second beat with no first beat before it, a valid second beat on a single-source operation, and single-precision data with non-zero low bits.

The core is a two-state machine:

- `S_IDLE` waits for a first beat.
  - Transition *open*: a valid first beat moves the machine to `S_WAIT_B`.
  - Transition *orphan*: a second-beat type seen in `S_IDLE` sets the orphan flag. The machine stays in `S_IDLE`.
  - Any other beat is ignored.
- `S_WAIT_B` holds the captured first-beat fields.
  - Transition *close*: a second-beat type completes the request and returns the machine to `S_IDLE`.
  - Transition *break*: any other ready beat sets the order flag, drops the pending request and returns the machine to `S_IDLE`.
  - Idle cycles keep the machine in `S_WAIT_B`.

Top module: `fpreq_pair_rx`

## Requirements
- R1: While reset is asserted and after it is released, `req_vld` is 0 and all four error flags are 0.
- R2: A ready beat whose bit 123 is 1 and whose bits 122:118 equal 0x0A is a first beat. A later ready beat whose bits 122:118 equal 0x0B closes the pair, with or without bit 123. One cycle after the closing beat is sampled, the outputs are set as follows: `req_vld` is 1; `req_tag` = first-beat bits 116:112; `req_opc` = bits 79:72; `req_rnd` = bits 71:70; `req_ccid` = bits 69:68; `req_src1` = first-beat bits 63:0; `req_src2` = closing-beat bits 63:0.
- R3: Cycles with `beat_rdy` low are stall cycles. Any number of them may lie between the two beats. They never close a pair, whatever `beat_word` holds during them.
- R4: When first-beat opcode bit 7 (word bit 79) is 1, the operation is single-source. Its `req_src2` is 0. If its closing beat has bit 123 set, `err_single_src` rises.
- R5: In `S_WAIT_B`, a ready beat whose type is not 0x0B sets `err_seq` and drops the pending request. No `req_vld` follows for that request.
- R6: In `S_IDLE`, a ready beat of type 0x0B sets `err_orphan`, and no `req_vld` follows.
- R7: A ready beat with bit 123 set, type 0x0A or 0x0B, opcode bit 1 (word bit 73) clear and bits 31:0 non-zero sets `err_sp_data`. With opcode bit 1 set, non-zero low bits raise no error.
- R8: Each error flag stays at 1 until reset. The active-low reset is asynchronous and clears the flags at once, without a clock edge.
- R9: `req_vld` is high for exactly one cycle per completed pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| beat_rdy | input | 1 | Qualifies `beat_word` in this cycle |
| beat_word | input | 124 | Incoming beat |
| req_vld | output | 1 | One-cycle pulse marking an assembled request |
| req_tag | output | 5 | Request tag |
| req_opc | output | 8 | Opcode |
| req_rnd | output | 2 | Rounding mode |
| req_ccid | output | 2 | Condition-code selector |
| req_src1 | output | 64 | First operand |
| req_src2 | output | 64 | Second operand, zero for single-source operations |
| err_seq | output | 1 | Sticky: broken beat order |
| err_orphan | output | 1 | Sticky: second beat with no first beat |
| err_single_src | output | 1 | Sticky: valid second beat on a single-source operation |
| err_sp_data | output | 1 | Sticky: single-precision operand with non-zero low half |

## Verification
The bench holds second-beat patterns on the word during stall cycles. A design that looked at the type without the ready strobe would close pairs early and emit a request carrying the wrong `req_src2`. Single-source requests are sent with non-zero data in the invalid closing beat; a design that did not gate the operand would pass that data through. A first beat followed by a foreign type, and then by a second beat, is sent to catch a design that kept the pending request after a break: it would emit a bogus request instead of flagging an orphan. The bench also checks that the flags persist over idle cycles and drop the moment reset falls, between clock edges.

// File: rtl/fpreq_pkg.sv
package fpreq_pkg;
    localparam int WORD_W     = 124;
    localparam int DATA_W     = 64;
    localparam int TAG_W      = 5;
    localparam int OPC_W      = 8;
    localparam int RND_W      = 2;
    localparam int CC_W       = 2;
    localparam int TYPE_W     = 5;
    localparam int VLD_BIT    = 123;
    localparam int TYPE_LO    = 118;
    localparam int TAG_LO     = 112;
    localparam int OPC_LO     = 72;
    localparam int RND_LO     = 70;
    localparam int CC_LO      = 68;
    localparam int OPC_SINGLE = 7;
    localparam int OPC_DBL    = 1;
    localparam int SP_LOW_W   = DATA_W / 2;
    localparam int ERR_N      = 4;
    localparam int ERR_SEQ    = 0;
    localparam int ERR_ORPH   = 1;
    localparam int ERR_SINGLE = 2;
    localparam int ERR_SP     = 3;

    localparam logic [TYPE_W-1:0] TYPE_FIRST  = 5'h0A;
    localparam logic [TYPE_W-1:0] TYPE_SECOND = 5'h0B;

    typedef enum logic {S_IDLE, S_WAIT_B} pair_state_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [OPC_W-1:0]  opc;
        logic [RND_W-1:0]  rnd;
        logic [CC_W-1:0]   cc;
        logic [DATA_W-1:0] data;
    } beat_fields_t;
endpackage

// File: rtl/fpreq_beat_decode.sv
module fpreq_beat_decode
    import fpreq_pkg::*;
(
    input  logic              rdy_i,
    input  logic [WORD_W-1:0] word_i,
    output beat_fields_t      fields_o,
    output logic              take_a_o,
    output logic              see_b_o,
    output logic              other_o,
    output logic              flag_vld_o,
    output logic              sp_bad_o
);
    logic [TYPE_W-1:0] ptype;
    logic              is_a_type;
    logic              is_b_type;

    always_comb begin
        ptype           = word_i[TYPE_LO +: TYPE_W];
        is_a_type       = (ptype == TYPE_FIRST);
        is_b_type       = (ptype == TYPE_SECOND);
        flag_vld_o      = word_i[VLD_BIT];
        fields_o.tag    = word_i[TAG_LO +: TAG_W];
        fields_o.opc    = word_i[OPC_LO +: OPC_W];
        fields_o.rnd    = word_i[RND_LO +: RND_W];
        fields_o.cc     = word_i[CC_LO +: CC_W];
        fields_o.data   = word_i[DATA_W-1:0];
        take_a_o        = rdy_i && flag_vld_o && is_a_type;
        see_b_o         = rdy_i && is_b_type;
        other_o         = rdy_i && !take_a_o && !see_b_o;
        sp_bad_o        = rdy_i && flag_vld_o && (is_a_type || is_b_type)
                          && !fields_o.opc[OPC_DBL]
                          && (|fields_o.data[SP_LOW_W-1:0]);
    end
endmodule

// File: rtl/fpreq_pair_fsm.sv
module fpreq_pair_fsm
    import fpreq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  beat_fields_t      fields_i,
    input  logic              take_a_i,
    input  logic              see_b_i,
    input  logic              other_i,
    input  logic              flag_vld_i,
    output logic              set_seq_o,
    output logic              set_orph_o,
    output logic              set_single_o,
    output logic              req_vld_o,
    output logic [TAG_W-1:0]  req_tag_o,
    output logic [OPC_W-1:0]  req_opc_o,
    output logic [RND_W-1:0]  req_rnd_o,
    output logic [CC_W-1:0]   req_cc_o,
    output logic [DATA_W-1:0] req_src1_o,
    output logic [DATA_W-1:0] req_src2_o
);
    pair_state_e  state_q;
    pair_state_e  state_d;
    beat_fields_t pend_q;
    logic         close_pair;
    logic         pend_single;

    assign pend_single = pend_q.opc[OPC_SINGLE];

    always_comb begin
        state_d      = state_q;
        close_pair   = 1'b0;
        set_seq_o    = 1'b0;
        set_orph_o   = 1'b0;
        set_single_o = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (take_a_i) begin
                    state_d = S_WAIT_B;
                end else if (see_b_i) begin
                    set_orph_o = 1'b1;
                end
            end
            S_WAIT_B: begin
                if (see_b_i) begin
                    close_pair   = 1'b1;
                    set_single_o = pend_single && flag_vld_i;
                    state_d      = S_IDLE;
                end else if (other_i || take_a_i) begin
                    set_seq_o = 1'b1;
                    state_d   = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // capture and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q     <= '0;
            req_vld_o  <= 1'b0;
            req_tag_o  <= '0;
            req_opc_o  <= '0;
            req_rnd_o  <= '0;
            req_cc_o   <= '0;
            req_src1_o <= '0;
            req_src2_o <= '0;
        end else begin
            req_vld_o <= close_pair;
            if (state_q == S_IDLE && take_a_i) begin
                pend_q <= fields_i;
            end
            if (close_pair) begin
                req_tag_o  <= pend_q.tag;
                req_opc_o  <= pend_q.opc;
                req_rnd_o  <= pend_q.rnd;
                req_cc_o   <= pend_q.cc;
                req_src1_o <= pend_q.data;
                req_src2_o <= pend_single ? '0 : fields_i.data;
            end
        end
    end

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_o |=> !req_vld_o);

    a_r4_single_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_o && req_opc_o[OPC_SINGLE]) |-> (req_src2_o == '0));

    a_r5_break_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_B && !see_b_i && (other_i || take_a_i)) |=> (!req_vld_o && state_q == S_IDLE));

    a_r6_orphan_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && see_b_i) |=> !req_vld_o);

    a_r3_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_B && !see_b_i && !other_i && !take_a_i) |=> (state_q == S_WAIT_B && !req_vld_o));
endmodule

// File: rtl/fpreq_err_flags.sv
module fpreq_err_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    output logic [N-1:0] flag_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_o[g] <= 1'b0;
            end else if (set_i[g]) begin
                flag_o[g] <= 1'b1;
            end
        end

        a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            flag_o[g] |=> flag_o[g]);

        a_r8_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> flag_o[g]);
    end
endmodule

// File: rtl/fpreq_pair_rx.sv
module fpreq_pair_rx
    import fpreq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                beat_rdy,
    input  logic [WORD_W-1:0]   beat_word,
    output logic                req_vld,
    output logic [TAG_W-1:0]    req_tag,
    output logic [OPC_W-1:0]    req_opc,
    output logic [RND_W-1:0]    req_rnd,
    output logic [CC_W-1:0]     req_ccid,
    output logic [DATA_W-1:0]   req_src1,
    output logic [DATA_W-1:0]   req_src2,
    output logic                err_seq,
    output logic                err_orphan,
    output logic                err_single_src,
    output logic                err_sp_data
);
    beat_fields_t     fields;
    logic             take_a;
    logic             see_b;
    logic             other;
    logic             flag_vld;
    logic             sp_bad;
    logic             set_seq;
    logic             set_orph;
    logic             set_single;
    logic [ERR_N-1:0] err_set;
    logic [ERR_N-1:0] err_flag;

    fpreq_beat_decode u_dec (
        .rdy_i      (beat_rdy),
        .word_i     (beat_word),
        .fields_o   (fields),
        .take_a_o   (take_a),
        .see_b_o    (see_b),
        .other_o    (other),
        .flag_vld_o (flag_vld),
        .sp_bad_o   (sp_bad)
    );

    fpreq_pair_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fields_i     (fields),
        .take_a_i     (take_a),
        .see_b_i      (see_b),
        .other_i      (other),
        .flag_vld_i   (flag_vld),
        .set_seq_o    (set_seq),
        .set_orph_o   (set_orph),
        .set_single_o (set_single),
        .req_vld_o    (req_vld),
        .req_tag_o    (req_tag),
        .req_opc_o    (req_opc),
        .req_rnd_o    (req_rnd),
        .req_cc_o     (req_ccid),
        .req_src1_o   (req_src1),
        .req_src2_o   (req_src2)
    );

    always_comb begin
        err_set             = '0;
        err_set[ERR_SEQ]    = set_seq;
        err_set[ERR_ORPH]   = set_orph;
        err_set[ERR_SINGLE] = set_single;
        err_set[ERR_SP]     = sp_bad;
    end

    fpreq_err_flags #(.N(ERR_N)) u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (err_set),
        .flag_o (err_flag)
    );

    assign err_seq        = err_flag[ERR_SEQ];
    assign err_orphan     = err_flag[ERR_ORPH];
    assign err_single_src = err_flag[ERR_SINGLE];
    assign err_sp_data    = err_flag[ERR_SP];

    a_r7_sp_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_rdy && beat_word[VLD_BIT] && !beat_word[OPC_LO + OPC_DBL]
         && (beat_word[TYPE_LO +: TYPE_W] == TYPE_FIRST)
         && (|beat_word[SP_LOW_W-1:0])) |=> err_sp_data);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (!req_vld && !err_seq && !err_orphan && !err_single_src && !err_sp_data));
endmodule

// File: tb/fpreq_pair_rx_tb.sv
module fpreq_pair_rx_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [4:0]  tag;
        logic [7:0]  opc;
        logic [1:0]  rnd;
        logic [1:0]  cc;
        logic [63:0] s1;
        logic [63:0] s2;
        logic [3:0]  stall;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{5'h03, 8'h42, 2'd1, 2'd2, 64'h4009_21FB_5444_2D18, 64'hC000_0000_1234_5678, 4'd0},
        '{5'h1F, 8'h86, 2'd3, 2'd0, 64'h3FF0_0000_0000_0001, 64'hDEAD_BEEF_CAFE_F00D, 4'd3},
        '{5'h10, 8'h40, 2'd2, 2'd3, 64'h3F80_0000_0000_0000, 64'h4000_0000_0000_0000, 4'd1},
        '{5'h00, 8'h83, 2'd0, 2'd1, 64'h0000_0000_0000_0007, 64'h1111_2222_3333_4444, 4'd5}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         beat_rdy = 1'b0;
    logic [123:0] beat_word = '0;
    logic         req_vld;
    logic [4:0]   req_tag;
    logic [7:0]   req_opc;
    logic [1:0]   req_rnd;
    logic [1:0]   req_ccid;
    logic [63:0]  req_src1;
    logic [63:0]  req_src2;
    logic         err_seq;
    logic         err_orphan;
    logic         err_single_src;
    logic         err_sp_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpreq_pair_rx u_dut (
        .clk(clk), .rst_n(rst_n), .beat_rdy(beat_rdy), .beat_word(beat_word),
        .req_vld(req_vld), .req_tag(req_tag), .req_opc(req_opc), .req_rnd(req_rnd),
        .req_ccid(req_ccid), .req_src1(req_src1), .req_src2(req_src2),
        .err_seq(err_seq), .err_orphan(err_orphan),
        .err_single_src(err_single_src), .err_sp_data(err_sp_data)
    );

    function automatic logic [123:0] mk(input logic v, input logic [4:0] ty,
        input logic [4:0] tag, input logic [7:0] opc, input logic [1:0] rnd,
        input logic [1:0] cc, input logic [63:0] data);
        logic [123:0] w;
        w = '0;
        w[123]     = v;
        w[122:118] = ty;
        w[116:112] = tag;
        w[79:72]   = opc;
        w[71:70]   = rnd;
        w[69:68]   = cc;
        w[63:0]    = data;
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic r, input logic [123:0] w);
        beat_rdy  = r;
        beat_word = w;
        tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        beat_rdy = 1'b0;
        beat_word = '0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic chk_flags(input logic [3:0] exp, input string req);
        logic [3:0] act;
        act = {err_sp_data, err_single_src, err_orphan, err_seq};
        chk(act == exp, req, 64'(act), 64'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: outputs quiet during reset
        chk(req_vld == 1'b0, "R1 vld in reset", 64'(req_vld), 64'd0);
        chk_flags(4'b0000, "R1 flags in reset");
        do_reset();
        chk(req_vld == 1'b0, "R1 vld after reset", 64'(req_vld), 64'd0);
        chk_flags(4'b0000, "R1 flags after reset");

        // R2 R3 R4 R9: table of legal pairs
        for (int i = 0; i < 4; i++) begin
            logic        single;
            logic [63:0] exp2;
            single = VECS[i].opc[7];
            exp2   = single ? 64'd0 : VECS[i].s2;
            drive(1'b1, mk(1'b1, 5'h0A, VECS[i].tag, VECS[i].opc, VECS[i].rnd, VECS[i].cc, VECS[i].s1));
            for (int s = 0; s < int'(VECS[i].stall); s++) begin
                drive(1'b0, mk(1'b1, 5'h0B, 5'h15, 8'hFF, 2'd3, 2'd3, 64'hFFFF));
                chk(req_vld == 1'b0, "R3 stall ignored", 64'(req_vld), 64'd0);
            end
            drive(1'b1, mk(!single, 5'h0B, VECS[i].tag, VECS[i].opc, VECS[i].rnd, VECS[i].cc, VECS[i].s2));
            chk(req_vld == 1'b1, "R2 vld", 64'(req_vld), 64'd1);
            chk(req_tag == VECS[i].tag, "R2 tag", 64'(req_tag), 64'(VECS[i].tag));
            chk(req_opc == VECS[i].opc, "R2 opc", 64'(req_opc), 64'(VECS[i].opc));
            chk(req_rnd == VECS[i].rnd, "R2 rnd", 64'(req_rnd), 64'(VECS[i].rnd));
            chk(req_ccid == VECS[i].cc, "R2 ccid", 64'(req_ccid), 64'(VECS[i].cc));
            chk(req_src1 == VECS[i].s1, "R2 src1", req_src1, VECS[i].s1);
            chk(req_src2 == exp2, "R4 R2 src2", req_src2, exp2);
            drive(1'b0, '0);
            chk(req_vld == 1'b0, "R9 pulse one cycle", 64'(req_vld), 64'd0);
        end
        // R7: double-precision low bits in the table raised nothing
        chk_flags(4'b0000, "R7 no error on legal traffic");

        // R6: orphan second beat
        drive(1'b1, mk(1'b1, 5'h0B, 5'h01, 8'h42, 2'd0, 2'd0, 64'h5));
        chk(req_vld == 1'b0, "R6 orphan no vld", 64'(req_vld), 64'd0);
        chk_flags(4'b0010, "R6 orphan flag");
        do_reset();

        // R5: broken order, then a second beat that must be an orphan
        drive(1'b1, mk(1'b1, 5'h0A, 5'h02, 8'h42, 2'd1, 2'd1, 64'h9));
        drive(1'b1, mk(1'b1, 5'h05, 5'h02, 8'h42, 2'd1, 2'd1, 64'h9));
        chk(req_vld == 1'b0, "R5 no vld on break", 64'(req_vld), 64'd0);
        chk_flags(4'b0001, "R5 seq flag");
        drive(1'b1, mk(1'b1, 5'h0B, 5'h02, 8'h42, 2'd1, 2'd1, 64'h9));
        chk(req_vld == 1'b0, "R5 pending dropped", 64'(req_vld), 64'd0);
        chk_flags(4'b0011, "R5 later beat orphan");
        do_reset();

        // R4: valid closing beat on a single-source operation
        drive(1'b1, mk(1'b1, 5'h0A, 5'h04, 8'h82, 2'd0, 2'd0, 64'h1));
        drive(1'b1, mk(1'b1, 5'h0B, 5'h04, 8'h82, 2'd0, 2'd0, 64'h77));
        chk_flags(4'b0100, "R4 single-source flag");
        chk(req_src2 == 64'd0, "R4 src2 zero", req_src2, 64'd0);
        do_reset();

        // R7: single-precision data with low bits set
        drive(1'b1, mk(1'b1, 5'h0A, 5'h06, 8'h40, 2'd0, 2'd0, 64'h3F80_0000_0000_0001));
        chk_flags(4'b1000, "R7 sp flag");

        // R8: sticky across idle cycles, then asynchronous clear
        for (int k = 0; k < 5; k++) drive(1'b0, '0);
        chk_flags(4'b1000, "R8 sticky");
        #2;
        rst_n = 1'b0;
        #1;
        chk_flags(4'b0000, "R8 async clear");
        @(negedge clk);
        rst_n = 1'b1;
        tick();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule